// File: doc/BRIEF.md
# Fully Associative Mixed-Page-Size Translation Buffer

This block turns a 32-bit virtual address into a physical address by searching every stored mapping at once. Each mapping covers a page of one of four sizes, and the page size sets how many address bits the compare uses. A mapping is tagged with a 4-bit address-space number, so several processes can hold mappings in the buffer together. A shared flag makes a mapping visible to every address space. The smallest page size splits each page into four 1K subpages, and each subpage can be enabled or disabled on its own.

The lookup path is purely combinational. From the address, the address-space number and the access direction it returns:
- a hit flag and a multi-hit flag,
- the index of the entry that won,
- the physical address,
- the protection group,
- the cache-inhibit and write-through attributes,
- a protection fault.

The fault comes from a per-group permission vector supplied by the surrounding registers. Software loads mappings one at a time through a write port. The write port places each new mapping at a round-robin replacement pointer, which the block exposes. An invalidate port clears one entry or all entries. On a miss the block only reports the miss, and software walks the page tables.

Top module: `fa_tlb`

## Requirements
- R1: All 32 entries are compared in parallel. `lk_hit` is 1 when at least one valid entry matches on page number, address space and subpage.
- R2: `wr_size` encodes the page size as 0=4K, 1=16K, 2=512K, 3=8M. The page-number compare covers only the virtual address bits at or above bit 12, 14, 19 or 23 respectively.
- R3: For a 4K entry, virtual address bits [11:10] select one bit of the entry's 4-bit subpage mask. The entry matches only if that bit is 1. For larger pages the mask is ignored.
- R4: An entry matches only if its address-space number equals `lk_asid`, unless the entry's shared flag is set, in which case the address space is not compared.
- R5: On a hit, `lk_pa` takes the winning entry's physical page bits at and above the page-size boundary and the virtual address bits below it.
- R6: When several entries match, the lowest-indexed one drives `lk_idx` and the attributes, and `lk_multi` is 1. `lk_multi` is 0 when fewer than two entries match.
- R7: On a hit, `lk_grp`, `lk_ci` and `lk_wt` equal the winning entry's group, cache-inhibit and write-through fields. On a miss, `lk_pa`, `lk_idx`, `lk_grp`, `lk_ci`, `lk_wt` and `lk_fault` are all 0.
- R8: Permission bit `grp_perm[2*g]` allows reads and bit `grp_perm[2*g+1]` allows writes for group g. `lk_fault` is 1 on a hit whose group does not permit the access type given by `lk_write` (1 = write).
- R9: A write loads the entry at `wr_ptr`. The pointer then advances by one and wraps from 31 to 0. Without a write the pointer holds its value.
- R10: `inv_en` with `inv_all`=1 clears every entry, and with `inv_all`=0 it clears entry `inv_idx`. A write in the same cycle still loads its entry as valid.
- R11: A synchronous reset clears every entry and sets `wr_ptr` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_va | input | 32 | Virtual address to translate |
| lk_asid | input | 4 | Current address-space number |
| lk_write | input | 1 | Access type, 1 = write |
| grp_perm | input | 32 | Read/write permission pair per protection group |
| lk_hit | output | 1 | A valid entry matched |
| lk_multi | output | 1 | More than one entry matched |
| lk_idx | output | 5 | Index of winning entry |
| lk_pa | output | 32 | Translated physical address |
| lk_grp | output | 4 | Protection group of winning entry |
| lk_ci | output | 1 | Cache-inhibit attribute |
| lk_wt | output | 1 | Write-through attribute |
| lk_fault | output | 1 | Access not permitted by the group |
| wr_en | input | 1 | Load a mapping at the replacement pointer |
| wr_vpn | input | 20 | Virtual page number (address bits 31:12) |
| wr_ppn | input | 20 | Physical page number (address bits 31:12) |
| wr_asid | input | 4 | Address-space number of the mapping |
| wr_shared | input | 1 | Mapping ignores the address space |
| wr_size | input | 2 | Page size code |
| wr_grp | input | 4 | Protection group |
| wr_ci | input | 1 | Cache-inhibit attribute |
| wr_wt | input | 1 | Write-through attribute |
| wr_sub | input | 4 | Subpage enable mask for 4K pages |
| wr_ptr | output | 5 | Current replacement pointer |
| inv_en | input | 1 | Invalidate request |
| inv_all | input | 1 | Invalidate every entry |
| inv_idx | input | 5 | Entry to invalidate |

## Verification
The bench aims at overlapping mappings of different sizes. If the priority or multi-hit logic were wrong, the design would return a higher entry or fail to flag the overlap. 4K lookups land on disabled subpages, and a design that ignored the mask would report hits there. Shared and private mappings are probed with foreign address spaces, which exposes a compare that always or never checks the address space. Large pages with dense offsets expose a wrong merge boundary, and the replacement pointer is pushed past its wrap. Writes that coincide with single and full invalidates show whether the load or the clear wins.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VA_W       = 32;
    localparam int BASE_SHIFT = 12;
    localparam int VPN_W      = VA_W - BASE_SHIFT;
    localparam int ASID_W     = 4;
    localparam int GRP_W      = 4;
    localparam int NGRP       = 1 << GRP_W;
    localparam int SUB_N      = 4;
    localparam int SUB_W      = $clog2(SUB_N);
    localparam int ENT_DEF    = 32;

    typedef enum logic [1:0] {
        PG_4K   = 2'd0,
        PG_16K  = 2'd1,
        PG_512K = 2'd2,
        PG_8M   = 2'd3
    } pg_size_e;

    typedef struct packed {
        logic              valid;
        logic [VPN_W-1:0]  vpn;
        logic [VPN_W-1:0]  ppn;
        logic [ASID_W-1:0] asid;
        logic              shared;
        pg_size_e          size;
        logic [GRP_W-1:0]  grp;
        logic              ci;
        logic              wt;
        logic [SUB_N-1:0]  sub;
    } tlb_ent_t;

    function automatic int unsigned pg_shift(pg_size_e s);
        case (s)
            PG_4K:   return 12;
            PG_16K:  return 14;
            PG_512K: return 19;
            default: return 23;
        endcase
    endfunction

    function automatic logic [VPN_W-1:0] vpn_mask(pg_size_e s);
        logic [VPN_W-1:0] low;
        low = VPN_W'((32'd1 << (pg_shift(s) - BASE_SHIFT)) - 32'd1);
        return ~low;
    endfunction

    function automatic logic [VA_W-1:0] off_mask(pg_size_e s);
        return VA_W'((64'd1 << pg_shift(s)) - 64'd1);
    endfunction
endpackage

// File: rtl/tlb_ent_match.sv
module tlb_ent_match
    import tlb_pkg::*;
(
    input  tlb_ent_t              ent,
    input  logic [VPN_W-1:0]      va_vpn,
    input  logic [SUB_W-1:0]      va_sub,
    input  logic [ASID_W-1:0]     asid,
    output logic                  match
);
    logic page_ok, space_ok, sub_ok;

    always_comb begin
        page_ok  = ((ent.vpn ^ va_vpn) & vpn_mask(ent.size)) == '0;
        space_ok = ent.shared || (ent.asid == asid);
        sub_ok   = (ent.size != PG_4K) || ent.sub[va_sub];
        match    = ent.valid && page_ok && space_ok && sub_ok;
    end
endmodule

// File: rtl/tlb_prio_sel.sv
module tlb_prio_sel #(
    parameter int N     = 32,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic             multi,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
        any   = |req;
        multi = |(req & (req - N'(1)));
    end
endmodule

// File: rtl/tlb_perm_chk.sv
module tlb_perm_chk
    import tlb_pkg::*;
(
    input  logic                  hit,
    input  logic [GRP_W-1:0]      grp,
    input  logic                  is_write,
    input  logic [2*NGRP-1:0]     perm,
    output logic                  fault
);
    logic allowed;

    always_comb begin
        allowed = perm[{grp, is_write}];
        fault   = hit && !allowed;
    end
endmodule

// File: rtl/fa_tlb.sv
module fa_tlb
    import tlb_pkg::*;
#(
    parameter int NUM_ENT = ENT_DEF,
    localparam int IDX_W  = $clog2(NUM_ENT)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [VA_W-1:0]      lk_va,
    input  logic [ASID_W-1:0]    lk_asid,
    input  logic                 lk_write,
    input  logic [2*NGRP-1:0]    grp_perm,
    output logic                 lk_hit,
    output logic                 lk_multi,
    output logic [IDX_W-1:0]     lk_idx,
    output logic [VA_W-1:0]      lk_pa,
    output logic [GRP_W-1:0]     lk_grp,
    output logic                 lk_ci,
    output logic                 lk_wt,
    output logic                 lk_fault,
    input  logic                 wr_en,
    input  logic [VPN_W-1:0]     wr_vpn,
    input  logic [VPN_W-1:0]     wr_ppn,
    input  logic [ASID_W-1:0]    wr_asid,
    input  logic                 wr_shared,
    input  logic [1:0]           wr_size,
    input  logic [GRP_W-1:0]     wr_grp,
    input  logic                 wr_ci,
    input  logic                 wr_wt,
    input  logic [SUB_N-1:0]     wr_sub,
    output logic [IDX_W-1:0]     wr_ptr,
    input  logic                 inv_en,
    input  logic                 inv_all,
    input  logic [IDX_W-1:0]     inv_idx
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_ENT - 1);

    tlb_ent_t           ents [NUM_ENT];
    logic [NUM_ENT-1:0] hits;
    logic               any_hit, many_hit;
    logic [IDX_W-1:0]   win;
    tlb_ent_t           sel;
    tlb_ent_t           new_ent;
    logic               fault_raw;

    // Storage: invalidates apply first, a same-cycle load lands afterwards.
    always_comb begin
        new_ent.valid  = 1'b1;
        new_ent.vpn    = wr_vpn;
        new_ent.ppn    = wr_ppn;
        new_ent.asid   = wr_asid;
        new_ent.shared = wr_shared;
        new_ent.size   = pg_size_e'(wr_size);
        new_ent.grp    = wr_grp;
        new_ent.ci     = wr_ci;
        new_ent.wt     = wr_wt;
        new_ent.sub    = wr_sub;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_ENT; i++) ents[i] <= '0;
            wr_ptr <= '0;
        end else begin
            if (inv_en) begin
                if (inv_all) begin
                    for (int i = 0; i < NUM_ENT; i++) ents[i].valid <= 1'b0;
                end else begin
                    ents[inv_idx].valid <= 1'b0;
                end
            end
            if (wr_en) begin
                ents[wr_ptr] <= new_ent;
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + IDX_W'(1);
            end
        end
    end

    // Parallel compare, one slice per entry.
    for (genvar g = 0; g < NUM_ENT; g++) begin : g_cmp
        tlb_ent_match u_match (
            .ent    (ents[g]),
            .va_vpn (lk_va[VA_W-1:BASE_SHIFT]),
            .va_sub (lk_va[BASE_SHIFT-1 -: SUB_W]),
            .asid   (lk_asid),
            .match  (hits[g])
        );
    end

    tlb_prio_sel #(.N(NUM_ENT), .IDX_W(IDX_W)) u_sel (
        .req   (hits),
        .any   (any_hit),
        .multi (many_hit),
        .idx   (win)
    );

    assign sel = ents[win];

    tlb_perm_chk u_perm (
        .hit      (any_hit),
        .grp      (sel.grp),
        .is_write (lk_write),
        .perm     (grp_perm),
        .fault    (fault_raw)
    );

    always_comb begin
        logic [VA_W-1:0] lo;
        lo       = off_mask(sel.size);
        lk_hit   = any_hit;
        lk_multi = many_hit;
        lk_idx   = any_hit ? win : '0;
        lk_pa    = any_hit ? (({sel.ppn, {BASE_SHIFT{1'b0}}} & ~lo) | (lk_va & lo)) : '0;
        lk_grp   = any_hit ? sel.grp : '0;
        lk_ci    = any_hit && sel.ci;
        lk_wt    = any_hit && sel.wt;
        lk_fault = fault_raw;
    end

    assert_ptr_advance_R9: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> wr_ptr == (($past(wr_ptr) == LAST) ? '0 : $past(wr_ptr) + IDX_W'(1)));
    assert_ptr_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(wr_ptr));
    assert_multi_needs_hit_R6: assert property (@(posedge clk) disable iff (rst)
        lk_multi |-> lk_hit);
    assert_fault_needs_hit_R8: assert property (@(posedge clk) disable iff (rst)
        lk_fault |-> lk_hit);
    assert_flush_empties_R10: assert property (@(posedge clk) disable iff (rst)
        (inv_en && inv_all && !wr_en) |=> !lk_hit);
    assert_offset_passes_R5: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> lk_pa[BASE_SHIFT-1:0] == lk_va[BASE_SHIFT-1:0]);
endmodule

// File: tb/fa_tlb_tb.sv
`timescale 1ns/1ps
module fa_tlb_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] lk_va;
    logic [3:0]  lk_asid;
    logic        lk_write;
    logic [31:0] grp_perm;
    logic        lk_hit, lk_multi, lk_ci, lk_wt, lk_fault;
    logic [4:0]  lk_idx, wr_ptr;
    logic [31:0] lk_pa;
    logic [3:0]  lk_grp;
    logic        wr_en, wr_shared, wr_ci, wr_wt, inv_en, inv_all;
    logic [19:0] wr_vpn, wr_ppn;
    logic [3:0]  wr_asid, wr_grp, wr_sub;
    logic [1:0]  wr_size;
    logic [4:0]  inv_idx;

    int checks = 0;
    int errors = 0;

    // reference state
    bit          m_v   [32];
    logic [19:0] m_vpn [32];
    logic [19:0] m_ppn [32];
    logic [3:0]  m_as  [32];
    bit          m_sh  [32];
    int          m_sz  [32];
    logic [3:0]  m_grp [32];
    bit          m_ci  [32];
    bit          m_wt  [32];
    logic [3:0]  m_sub [32];
    int          m_ptr;

    always #10 clk = ~clk;

    fa_tlb dut_i (
        .clk(clk), .rst(rst), .lk_va(lk_va), .lk_asid(lk_asid), .lk_write(lk_write),
        .grp_perm(grp_perm), .lk_hit(lk_hit), .lk_multi(lk_multi), .lk_idx(lk_idx),
        .lk_pa(lk_pa), .lk_grp(lk_grp), .lk_ci(lk_ci), .lk_wt(lk_wt), .lk_fault(lk_fault),
        .wr_en(wr_en), .wr_vpn(wr_vpn), .wr_ppn(wr_ppn), .wr_asid(wr_asid),
        .wr_shared(wr_shared), .wr_size(wr_size), .wr_grp(wr_grp), .wr_ci(wr_ci),
        .wr_wt(wr_wt), .wr_sub(wr_sub), .wr_ptr(wr_ptr), .inv_en(inv_en),
        .inv_all(inv_all), .inv_idx(inv_idx)
    );

    initial begin
        #(200000 * 20);
        checks++; errors++;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
        end
    endtask

    function automatic int shift_of(int sz);
        case (sz)
            0: return 12;
            1: return 14;
            2: return 19;
            default: return 23;
        endcase
    endfunction

    // compare outputs against the behavioural model for the present inputs
    task automatic compare();
        int first = -1;
        int cnt = 0;
        logic [31:0] epa = 0;
        logic [31:0] pg, mask;
        bit ok_r, ok_w, efault;
        for (int i = 0; i < 32; i++) begin
            int sh = shift_of(m_sz[i]);
            bit m;
            pg = {m_vpn[i], 12'h000};
            m  = m_v[i] && ((pg >> sh) == (lk_va >> sh)) &&
                 (m_sh[i] || m_as[i] == lk_asid) &&
                 (m_sz[i] != 0 || m_sub[i][lk_va[11:10]]);
            if (m) begin
                cnt++;
                if (first < 0) first = i;
            end
        end
        if (first >= 0) begin
            int sh = shift_of(m_sz[first]);
            mask = (32'd1 << sh) - 1;
            epa  = ({m_ppn[first], 12'h000} & ~mask) | (lk_va & mask);
            ok_r = grp_perm[2 * m_grp[first]];
            ok_w = grp_perm[2 * m_grp[first] + 1];
            efault = lk_write ? !ok_w : !ok_r;
        end else efault = 0;
        chk(lk_hit == (first >= 0), "R1 hit", 32'(lk_hit), 32'(first >= 0));
        chk(lk_multi == (cnt > 1), "R6 multi", 32'(lk_multi), 32'(cnt > 1));
        chk(lk_idx == ((first >= 0) ? 5'(first) : 5'd0), "R6 index", 32'(lk_idx),
            (first >= 0) ? 32'(first) : 32'd0);
        chk(lk_pa == epa, "R5 pa", lk_pa, epa);
        chk({lk_grp, lk_ci, lk_wt} == ((first >= 0) ? {m_grp[first], m_ci[first], m_wt[first]} : 6'd0),
            "R7 attrs", 32'({lk_grp, lk_ci, lk_wt}),
            (first >= 0) ? 32'({m_grp[first], m_ci[first], m_wt[first]}) : 32'd0);
        chk(lk_fault == efault, "R8 fault", 32'(lk_fault), 32'(efault));
        chk(wr_ptr == 5'(m_ptr), "R9 pointer", 32'(wr_ptr), 32'(m_ptr));
    endtask

    task automatic model_clock();
        if (rst) begin
            for (int i = 0; i < 32; i++) m_v[i] = 0;
            m_ptr = 0;
        end else begin
            if (inv_en) begin
                if (inv_all) for (int i = 0; i < 32; i++) m_v[i] = 0;
                else m_v[inv_idx] = 0;
            end
            if (wr_en) begin
                m_v[m_ptr] = 1; m_vpn[m_ptr] = wr_vpn; m_ppn[m_ptr] = wr_ppn;
                m_as[m_ptr] = wr_asid; m_sh[m_ptr] = wr_shared; m_sz[m_ptr] = int'(wr_size);
                m_grp[m_ptr] = wr_grp; m_ci[m_ptr] = wr_ci; m_wt[m_ptr] = wr_wt;
                m_sub[m_ptr] = wr_sub;
                m_ptr = (m_ptr + 1) % 32;
            end
        end
    endtask

    task automatic cyc();
        #1;
        if (!rst) compare();
        @(posedge clk);
        model_clock();
        @(negedge clk);
    endtask

    task automatic look(input logic [31:0] va, input logic [3:0] as, input bit w);
        lk_va = va; lk_asid = as; lk_write = w;
        cyc();
    endtask

    task automatic load(input logic [19:0] vpn, input logic [19:0] ppn, input logic [3:0] as,
                        input bit sh, input logic [1:0] sz, input logic [3:0] grp,
                        input bit ci, input bit wt, input logic [3:0] sub);
        wr_en = 1; wr_vpn = vpn; wr_ppn = ppn; wr_asid = as; wr_shared = sh;
        wr_size = sz; wr_grp = grp; wr_ci = ci; wr_wt = wt; wr_sub = sub;
        cyc();
        wr_en = 0;
    endtask

    initial begin
        rst = 1; lk_va = 0; lk_asid = 0; lk_write = 0;
        wr_en = 0; wr_vpn = 0; wr_ppn = 0; wr_asid = 0; wr_shared = 0; wr_size = 0;
        wr_grp = 0; wr_ci = 0; wr_wt = 0; wr_sub = 0; inv_en = 0; inv_all = 0; inv_idx = 0;
        // all groups read+write, group 3 read only, group 5 nothing
        grp_perm = 32'hFFFF_FFFF;
        grp_perm[7] = 0;
        grp_perm[10] = 0; grp_perm[11] = 0;
        @(negedge clk);
        cyc(); cyc();
        // R11: reset state
        #1;
        chk(lk_hit == 0, "R11 reset hit", 32'(lk_hit), 0);
        chk(wr_ptr == 0, "R11 reset pointer", 32'(wr_ptr), 0);
        rst = 0;
        look(32'h1234_5000, 4'd1, 0);

        // 4K entry, subpage mask 1011, group 3 read only (R3, R8)
        load(20'h12345, 20'hABCDE, 4'd1, 0, 2'd0, 4'd3, 1, 0, 4'b1011);
        look(32'h1234_5123, 4'd1, 0);
        look(32'h1234_5800, 4'd1, 0);   // R3 disabled subpage 2
        look(32'h1234_5C44, 4'd1, 0);   // R3 enabled subpage 3
        look(32'h1234_5123, 4'd2, 0);   // R4 foreign space
        look(32'h1234_5123, 4'd1, 1);   // R8 write to read-only group

        // 8M shared page in group 5 (R2, R4, R5, R8)
        load(20'h80000, 20'h00800, 4'd9, 1, 2'd3, 4'd5, 0, 1, 4'b0000);
        look(32'h807A_BCDE, 4'd7, 0);
        look(32'h80FF_FFFF, 4'd0, 1);
        look(32'h8100_0000, 4'd0, 0);

        // 16K overlapping the 4K entry (R6), 512K private (R2)
        load(20'h12344, 20'h55554, 4'd1, 0, 2'd1, 4'd2, 0, 0, 4'b0000);
        load(20'h40000, 20'h3FF80, 4'd2, 0, 2'd2, 4'd1, 1, 1, 4'b0000);
        look(32'h1234_5010, 4'd1, 0);
        look(32'h1234_6010, 4'd1, 0);
        look(32'h1234_5810, 4'd1, 0);
        look(32'h4007_FFF0, 4'd2, 0);
        look(32'h4008_0000, 4'd2, 0);

        // R10: single invalidate, then write and invalidate in same cycle
        inv_en = 1; inv_all = 0; inv_idx = 5'd0;
        look(32'h1234_5010, 4'd1, 0);
        inv_idx = 5'd4;
        load(20'h00001, 20'h00002, 4'd0, 1, 2'd0, 4'd0, 0, 0, 4'b1111);
        inv_en = 0;
        look(32'h1234_5010, 4'd1, 0);
        look(32'h0000_1FFF, 4'd6, 0);

        // R9: fill past the wrap with mixed traffic
        for (int n = 0; n < 80; n++) begin
            int k = $urandom_range(31);
            load(20'($urandom), 20'($urandom), 4'($urandom_range(3)), 1'($urandom_range(1)),
                 2'($urandom_range(3)), 4'($urandom), 1'($urandom_range(1)),
                 1'($urandom_range(1)), 4'($urandom));
            look({m_vpn[k], 12'($urandom)}, 4'($urandom_range(3)), 1'($urandom_range(1)));
            if (n % 17 == 5) begin
                inv_en = 1; inv_all = 0; inv_idx = 5'($urandom);
                look({m_vpn[k], 12'($urandom)}, m_as[k], 0);
                inv_en = 0;
            end
        end

        // R10: flush all together with a load
        inv_en = 1; inv_all = 1;
        load(20'h77777, 20'h11111, 4'd3, 0, 2'd0, 4'd0, 1, 1, 4'b0001);
        inv_en = 0;
        look(32'h7777_7300, 4'd3, 0);
        look({m_vpn[5], 12'h000}, m_as[5], 0);
        inv_en = 1; inv_all = 1;
        cyc();
        inv_en = 0;
        look(32'h7777_7300, 4'd3, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule